// File: doc/BRIEF.md
# DMA Transfer Count and Start Address Registers

This block holds the setup state for a DMA transfer engine. A single word-sized count register carries a 14-bit transfer count, a direction flag and an enable flag. The CPU can read the count back. The DMA start address is loaded differently from most registers. It is taken from the CPU address lines of a write strobe, not from the data bus. Address bit 14 of that write selects which part of the start address is replaced.

A write to the count register does not store the data count as written. The stored count is one more than the written value, and it wraps inside 14 bits. The start address is word aligned: its bit 0 is always zero. Bits 8:1 come from a write with address bit 14 low. Bits 21:9 come from a write with address bit 14 high, which supplies address bits 13:1. The transfer engine reads the count, direction, enable and start address from dedicated outputs.

Top module: `dmareg_regs`

## Requirements
- R1: While reset is held, and after it is released, the count, direction, enable and start address outputs are all zero.
- R2: A word-sized count write (cnt_wr=1, cpu_word=1) loads direction from data bit 14 and enable from data bit 15.
- R3: After a word-sized count write, the stored count is data bits 13:0 plus one, modulo 2^14, so a written 0x3FFF leaves a count of 0.
- R4: The count read port returns the 14-bit count in bits 13:0, with bits 15 and 14 always 1.
- R5: A count write with cpu_word=0 (byte access) leaves count, direction and enable unchanged.
- R6: An address write (adr_wr=1) with cpu_addr bit 14 low replaces start-address bits 8:1 with cpu_addr bits 8:1 and keeps bits 21:9.
- R7: An address write with cpu_addr bit 14 high replaces start-address bits 21:9 with cpu_addr bits 13:1 and keeps bits 8:1.
- R8: Start-address bit 0 is always 0, whatever cpu_addr bit 0 is during an address write.
- R9: A count write and an address write in the same cycle both take effect.
- R10: With no write strobe asserted, all stored state holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_wr | input | 1 | Count register write strobe |
| adr_wr | input | 1 | Start address write strobe |
| cpu_word | input | 1 | 1 for a word-sized access, 0 for a byte access |
| cpu_addr | input | 16 | CPU address bits 15:0 of the access |
| cpu_wdata | input | 16 | CPU write data |
| cnt_rdata | output | 16 | Count register read value |
| dma_count | output | 14 | Stored transfer count |
| dma_dir | output | 1 | Transfer direction flag |
| dma_en | output | 1 | Transfer enable flag |
| dma_addr | output | 22 | DMA start address |

## Verification
The count write and the address write share the CPU address and data inputs, and both strobes may be asserted in one cycle. The bench raises both strobes together. It drives a data word that sets the count and enable fields and an address with bit 14 high that moves the upper start-address field. It then checks that the incremented count, the flags and the new upper field all appear one cycle later. It also checks that the lower field is kept. Each unit must treat the shared inputs as its own; neither may block or corrupt the other.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;
    parameter int CNT_W   = 14;
    parameter int LO_W    = 8;
    parameter int HI_W    = 13;
    parameter int CPU_AW  = 16;
    parameter int CPU_DW  = 16;
    parameter int SEL_BIT = 14;
    localparam int ADR_W  = 1 + LO_W + HI_W;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             dir;
        logic             en;
    } cnt_state_t;

    typedef struct packed {
        logic [HI_W-1:0] hi;
        logic [LO_W-1:0] lo;
    } adr_state_t;
endpackage

// File: rtl/dmareg_count_unit.sv
module dmareg_count_unit
    import dmareg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              word,
    input  logic [CPU_DW-1:0] wdata,
    output cnt_state_t        state
);
    cnt_state_t st_d, st_q;
    logic       accept;

    always_comb begin
        accept = wr && word;
        st_d   = st_q;
        if (accept) begin
            st_d.count = wdata[CNT_W-1:0] + CNT_W'(1);
            st_d.dir   = wdata[CNT_W];
            st_d.en    = wdata[CNT_W+1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign state = st_q;

    // R3: stored count is the written count plus one
    a_r3_count_plus_one: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && word) |=> (st_q.count == CNT_W'($past(wdata[CNT_W-1:0]) + 1)));
    // R2: flags follow data bits 14 and 15
    a_r2_flags_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && word) |=> (st_q.dir == $past(wdata[CNT_W]) && st_q.en == $past(wdata[CNT_W+1])));
    // R5: byte-sized access leaves the register alone
    a_r5_byte_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr && word)) |=> $stable(st_q));
endmodule

// File: rtl/dmareg_addr_unit.sv
module dmareg_addr_unit
    import dmareg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [CPU_AW-1:0] addr,
    output logic [ADR_W-1:0]  dma_addr
);
    adr_state_t st_d, st_q;
    logic       sel_hi;

    always_comb begin
        sel_hi = addr[SEL_BIT];
        st_d   = st_q;
        if (wr) begin
            if (sel_hi) st_d.hi = addr[HI_W:1];
            else        st_d.lo = addr[LO_W:1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dma_addr = {st_q.hi, st_q.lo, 1'b0};

    // R6: low-half write keeps the upper field
    a_r6_low_keeps_high: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !addr[SEL_BIT]) |=> ($stable(st_q.hi) && st_q.lo == $past(addr[LO_W:1])));
    // R7: high-half write keeps the lower field
    a_r7_high_keeps_low: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr[SEL_BIT]) |=> ($stable(st_q.lo) && st_q.hi == $past(addr[HI_W:1])));
    // R10: no strobe, no change
    a_r10_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr) |=> $stable(st_q));
endmodule

// File: rtl/dmareg_regs.sv
module dmareg_regs
    import dmareg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_wr,
    input  logic              adr_wr,
    input  logic              cpu_word,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [CPU_DW-1:0] cpu_wdata,
    output logic [CPU_DW-1:0] cnt_rdata,
    output logic [CNT_W-1:0]  dma_count,
    output logic              dma_dir,
    output logic              dma_en,
    output logic [ADR_W-1:0]  dma_addr
);
    localparam int PAD_W = CPU_DW - CNT_W;

    cnt_state_t cst;

    dmareg_count_unit u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (cnt_wr),
        .word  (cpu_word),
        .wdata (cpu_wdata),
        .state (cst)
    );

    dmareg_addr_unit u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (adr_wr),
        .addr     (cpu_addr),
        .dma_addr (dma_addr)
    );

    assign dma_count = cst.count;
    assign dma_dir   = cst.dir;
    assign dma_en    = cst.en;
    assign cnt_rdata = {{PAD_W{1'b1}}, cst.count};

    // R8: start address stays word aligned across any address write
    a_r8_addr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        adr_wr |=> (dma_addr[0] == 1'b0));
    // R9: simultaneous writes both land
    a_r9_both_land: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr && cpu_word && adr_wr && cpu_addr[SEL_BIT]) |=>
        (dma_count == CNT_W'($past(cpu_wdata[CNT_W-1:0]) + 1) &&
         dma_addr[ADR_W-1:LO_W+1] == $past(cpu_addr[HI_W:1])));
endmodule

// File: tb/tb_dmareg_regs.sv
module tb_dmareg_regs;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_wr = 1'b0, adr_wr = 1'b0, cpu_word = 1'b0;
    logic [15:0] cpu_addr = '0, cpu_wdata = '0;
    logic [15:0] cnt_rdata;
    logic [13:0] dma_count;
    logic        dma_dir, dma_en;
    logic [21:0] dma_addr;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmareg_regs dut (
        .clk(clk), .rst_n(rst_n), .cnt_wr(cnt_wr), .adr_wr(adr_wr),
        .cpu_word(cpu_word), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cnt_rdata(cnt_rdata), .dma_count(dma_count), .dma_dir(dma_dir),
        .dma_en(dma_en), .dma_addr(dma_addr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic access(input logic cw, input logic aw, input logic word,
                          input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        cnt_wr = cw; adr_wr = aw; cpu_word = word; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cnt_wr = 1'b0; adr_wr = 1'b0; cpu_word = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    endtask

    task automatic t_reset();
        repeat (2) @(negedge clk);
        check("R1 count", 32'(dma_count), 0);
        check("R1 flags", {30'd0, dma_dir, dma_en}, 0);
        check("R1 addr", 32'(dma_addr), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 addr after release", 32'(dma_addr), 0);
        check("R4 read after reset", 32'(cnt_rdata), 32'hC000);
    endtask

    task automatic t_count_basic();
        access(1, 0, 1, 16'h0000, 16'hC123);
        check("R3 count", 32'(dma_count), 32'h0124);
        check("R2 dir", 32'(dma_dir), 1);
        check("R2 en", 32'(dma_en), 1);
        check("R4 read", 32'(cnt_rdata), 32'hC124);
        access(1, 0, 1, 16'h0000, 16'h4005);
        check("R3 count2", 32'(dma_count), 6);
        check("R2 dir2", 32'(dma_dir), 1);
        check("R2 en2", 32'(dma_en), 0);
    endtask

    task automatic t_count_wrap();
        access(1, 0, 1, 16'h0000, 16'h3FFF);
        check("R3 wrap", 32'(dma_count), 0);
        check("R4 wrap read", 32'(cnt_rdata), 32'hC000);
        check("R2 flags clear", {30'd0, dma_dir, dma_en}, 0);
    endtask

    task automatic t_byte_ignored();
        access(1, 0, 1, 16'h0000, 16'h4005);
        access(1, 0, 0, 16'h0000, 16'h8010);
        check("R5 count kept", 32'(dma_count), 6);
        check("R5 flags kept", {30'd0, dma_dir, dma_en}, 2);
    endtask

    task automatic t_addr_halves();
        access(0, 1, 0, 16'h01A5, 16'hFFFF);
        check("R6 low write", 32'(dma_addr), 32'h0001A4);
        check("R8 bit0", 32'(dma_addr[0]), 0);
        access(0, 1, 1, 16'h6ABC, 16'h0000);
        check("R7 high write", 32'(dma_addr), 32'h2ABDA4);
        access(0, 1, 0, 16'h00FF, 16'h0000);
        check("R6 keeps high", 32'(dma_addr), 32'h2ABCFE);
        check("R5 addr write leaves count", 32'(dma_count), 6);
    endtask

    task automatic t_same_cycle();
        access(1, 1, 1, 16'h4002, 16'h8002);
        check("R9 count", 32'(dma_count), 3);
        check("R9 en", 32'(dma_en), 1);
        check("R9 addr", 32'(dma_addr), 32'h0002FE);
    endtask

    task automatic t_idle_hold();
        repeat (5) @(negedge clk);
        check("R10 count", 32'(dma_count), 3);
        check("R10 addr", 32'(dma_addr), 32'h0002FE);
        check("R10 read", 32'(cnt_rdata), 32'hC003);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_count_basic();
                t_count_wrap();
                t_byte_ignored();
                t_addr_halves();
                t_same_cycle();
                t_idle_hold();
            end
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule